// File: doc/BRIEF.md
# Critical Limit Monitor with Hysteresis

This block watches three 8-bit channel readings (a sense voltage, a source voltage and an internal temperature) and compares each against its own programmable critical limit. A channel trips when its reading reaches or passes the limit. It stays tripped until a later reading falls below the limit minus that channel's hysteresis value. The three trip flags form a status byte that is not cleared by reads. An OR of the flags gives a summary critical bit, and any trip pulls the active-low thermal shutdown output low. Comparisons run only on a sample strobe, so the readings may change freely between conversions.

A second function routes the single-cycle spike pulse from an external peak detector. A routing input picks the destination. When the spike goes to the thermal output, no mask can block it. When it goes to the alert request, the peak mask input can block it. A captured spike stays held until the next sample strobe. The routing bit is held outside the block in a configuration register whose reset value selects the thermal output.

Each channel has a two-state machine. CH_CLEAR moves to CH_TRIP on a strobe whose reading is at or above the limit (transition "trip"). CH_TRIP moves back to CH_CLEAR on a strobe whose reading is below the saturated release threshold (transition "release"). The spike router has one machine for each destination. SP_IDLE moves to SP_HELD on an accepted spike (transition "capture"). SP_HELD moves back to SP_IDLE on a strobe with no accepted spike in the same cycle (transition "drop").

Top module: `crit_guard`

## Requirements
- R1: After reset, crit_stat is 8'h00, crit_sum is 0, therm_n is 1 and alert_spike is 0.
- R2: On a cycle with smp_stb high, a clear channel trips when its reading is greater than or equal to its limit (unsigned). Status bit 7 is the sense channel, bit 6 the source channel and bit 0 the temperature channel. Bits 5 to 1 always read 0.
- R3: On a strobe, a tripped channel clears only when its reading is below its release threshold. The threshold is limit minus hysteresis, or 0 when the hysteresis is equal to or larger than the limit, so such a channel never clears. Otherwise the channel stays tripped.
- R4: Changing readings, limits or hysteresis without smp_stb leaves crit_stat unchanged.
- R5: A pulse on rd_stb never clears or changes any status bit.
- R6: crit_sum is 1 exactly when at least one bit of crit_stat is 1.
- R7: therm_n is 0 whenever any crit bit is set.
- R8: A spike pulse with route_therm=1 is captured whatever peak_mask is. It holds therm_n at 0 from the next cycle until the edge of a later strobe cycle that has no spike.
- R9: A spike pulse with route_therm=0 and peak_mask=0 raises alert_spike from the next cycle until the next strobe edge, and leaves therm_n alone. With peak_mask=1 the same pulse is ignored.
- R10: When a spike and smp_stb arrive in the same cycle, the new spike is held and the strobe does not drop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One cycle per completed conversion; compares and releases spikes |
| rd_stb | input | 1 | Status byte read by the register interface |
| sense_rd | input | 8 | Sense voltage reading |
| src_rd | input | 8 | Source voltage reading |
| temp_rd | input | 8 | Internal temperature reading |
| sense_lim | input | 8 | Sense voltage critical limit |
| src_lim | input | 8 | Source voltage critical limit |
| temp_lim | input | 8 | Temperature critical limit |
| sense_hys | input | 8 | Sense voltage hysteresis |
| src_hys | input | 8 | Source voltage hysteresis |
| temp_hys | input | 8 | Temperature hysteresis |
| spike | input | 1 | Current-spike pulse from the peak detector |
| route_therm | input | 1 | 1 sends spikes to therm_n, 0 to alert_spike |
| peak_mask | input | 1 | Blocks spikes routed to the alert request |
| crit_stat | output | 8 | Critical status byte |
| crit_sum | output | 1 | OR of all critical bits |
| therm_n | output | 1 | Active-low thermal shutdown |
| alert_spike | output | 1 | Alert request from a held spike |

## Verification
The collision that matters is a spike pulse arriving on the same cycle as the sample strobe, which is also the cycle that releases the previous held spike. The bench first holds a spike, then drives a new spike together with smp_stb. It expects the destination to stay held after that edge, and to drop only on a later strobe with no spike. A second collision is a read strobe landing on the same cycle as a compare strobe. During the exhaustive limit and hysteresis sweeps, read strobes are scattered among the compare strobes, and each result is judged against a model that ignores reads entirely.

// File: rtl/crit_pkg.sv
package crit_pkg;

    localparam int unsigned NCH       = 3;
    localparam int unsigned STAT_W    = 8;
    localparam int unsigned POS_SENSE = 7;
    localparam int unsigned POS_SRC   = 6;
    localparam int unsigned POS_TEMP  = 0;
    localparam int unsigned NDEST     = 2;
    localparam int unsigned DEST_THRM = 0;
    localparam int unsigned DEST_ALRT = 1;

    typedef enum logic {
        CH_CLEAR = 1'b0,
        CH_TRIP  = 1'b1
    } chan_st_e;

    typedef enum logic {
        SP_IDLE = 1'b0,
        SP_HELD = 1'b1
    } spk_st_e;

    function automatic int unsigned chan_pos(input int unsigned idx);
        unique case (idx)
            0:       return POS_SENSE;
            1:       return POS_SRC;
            default: return POS_TEMP;
        endcase
    endfunction

endpackage

// File: rtl/crit_chan.sv
module crit_chan
    import crit_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_stb,
    input  logic [W-1:0] rd,
    input  logic [W-1:0] lim,
    input  logic [W-1:0] hys,
    output logic         tripped
);

    chan_st_e     st, st_nx;
    logic [W-1:0] rel_thr;

    // release threshold saturates at zero
    always_comb begin
        if (lim > hys) rel_thr = lim - hys;
        else           rel_thr = '0;
    end

    always_comb begin
        st_nx = st;
        if (smp_stb) begin
            unique case (st)
                CH_CLEAR: if (rd >= lim)    st_nx = CH_TRIP;
                CH_TRIP:  if (rd < rel_thr) st_nx = CH_CLEAR;
                default:                    st_nx = CH_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_CLEAR;
        else        st <= st_nx;
    end

    always_comb tripped = (st == CH_TRIP);

    a_r2_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && st == CH_CLEAR && rd >= lim) |=> (st == CH_TRIP));

    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && st == CH_TRIP && ({1'b0, rd} + {1'b0, hys} < {1'b0, lim}))
        |=> (st == CH_CLEAR));

    a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && st == CH_TRIP && ({1'b0, rd} + {1'b0, hys} >= {1'b0, lim}))
        |=> (st == CH_TRIP));

    a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(st));

endmodule

// File: rtl/spike_router.sv
module spike_router
    import crit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_stb,
    input  logic spike,
    input  logic route_therm,
    input  logic peak_mask,
    output logic therm_held,
    output logic alert_held
);

    logic [NDEST-1:0] accept;
    logic [NDEST-1:0] held;

    always_comb begin
        accept            = '0;
        accept[DEST_THRM] = spike &&  route_therm;
        accept[DEST_ALRT] = spike && !route_therm && !peak_mask;
    end

    for (genvar d = 0; d < NDEST; d++) begin : g_dest
        spk_st_e st, st_nx;

        always_comb begin
            st_nx = st;
            unique case (st)
                SP_IDLE: if (accept[d])             st_nx = SP_HELD;
                SP_HELD: if (smp_stb && !accept[d]) st_nx = SP_IDLE;
                default:                            st_nx = SP_IDLE;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= SP_IDLE;
            else        st <= st_nx;
        end

        always_comb held[d] = (st == SP_HELD);
    end

    always_comb begin
        therm_held = held[DEST_THRM];
        alert_held = held[DEST_ALRT];
    end

    a_r8_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        (spike && route_therm) |=> therm_held);

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (spike && !route_therm && peak_mask && !alert_held) |=> !alert_held);

    a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (spike && smp_stb && !route_therm && !peak_mask) |=> alert_held);

endmodule

// File: rtl/crit_guard.sv
module crit_guard
    import crit_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              rd_stb,
    input  logic [W-1:0]      sense_rd,
    input  logic [W-1:0]      src_rd,
    input  logic [W-1:0]      temp_rd,
    input  logic [W-1:0]      sense_lim,
    input  logic [W-1:0]      src_lim,
    input  logic [W-1:0]      temp_lim,
    input  logic [W-1:0]      sense_hys,
    input  logic [W-1:0]      src_hys,
    input  logic [W-1:0]      temp_hys,
    input  logic              spike,
    input  logic              route_therm,
    input  logic              peak_mask,
    output logic [STAT_W-1:0] crit_stat,
    output logic              crit_sum,
    output logic              therm_n,
    output logic              alert_spike
);

    logic [W-1:0]   rd_a  [NCH];
    logic [W-1:0]   lim_a [NCH];
    logic [W-1:0]   hys_a [NCH];
    logic [NCH-1:0] trip;
    logic           therm_held;
    logic           alert_held;

    always_comb begin
        rd_a[0]  = sense_rd;  rd_a[1]  = src_rd;  rd_a[2]  = temp_rd;
        lim_a[0] = sense_lim; lim_a[1] = src_lim; lim_a[2] = temp_lim;
        hys_a[0] = sense_hys; hys_a[1] = src_hys; hys_a[2] = temp_hys;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        crit_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .rd      (rd_a[c]),
            .lim     (lim_a[c]),
            .hys     (hys_a[c]),
            .tripped (trip[c])
        );
    end

    spike_router u_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_stb     (smp_stb),
        .spike       (spike),
        .route_therm (route_therm),
        .peak_mask   (peak_mask),
        .therm_held  (therm_held),
        .alert_held  (alert_held)
    );

    always_comb begin
        crit_stat = '0;
        for (int i = 0; i < NCH; i++) crit_stat[chan_pos(i)] = trip[i];
    end

    always_comb begin
        crit_sum    = |trip;
        therm_n     = !(crit_sum || therm_held);
        alert_spike = alert_held;
    end

    a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !smp_stb) |=> $stable(crit_stat));

    a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
        crit_sum == (crit_stat != '0));

    a_r7_therm: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_stat != '0) |-> !therm_n);

    a_r2_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
        crit_stat[5:1] == '0);

endmodule

// File: tb/tb_crit_guard.sv
module tb_crit_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] sense_rd = '0, src_rd = '0, temp_rd = '0;
    logic [7:0] sense_lim = 8'hFF, src_lim = 8'hFF, temp_lim = 8'hFF;
    logic [7:0] sense_hys = '0, src_hys = '0, temp_hys = '0;
    logic       spike = 1'b0, route_therm = 1'b1, peak_mask = 1'b0;
    logic [7:0] crit_stat;
    logic       crit_sum, therm_n, alert_spike;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit e_s, e_v, e_t;

    always #10 clk = ~clk;

    crit_guard dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .rd_stb(rd_stb),
        .sense_rd(sense_rd), .src_rd(src_rd), .temp_rd(temp_rd),
        .sense_lim(sense_lim), .src_lim(src_lim), .temp_lim(temp_lim),
        .sense_hys(sense_hys), .src_hys(src_hys), .temp_hys(temp_hys),
        .spike(spike), .route_therm(route_therm), .peak_mask(peak_mask),
        .crit_stat(crit_stat), .crit_sum(crit_sum), .therm_n(therm_n),
        .alert_spike(alert_spike)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model(input bit st, input int r, input int l, input int h);
        int thr = (l > h) ? l - h : 0;
        if (!st && r >= l) return 1'b1;
        if (st && r < thr) return 1'b0;
        return st;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_stb = 0; spike = 0; rd_stb = 0;
        @(negedge clk);
        rst_n = 1'b1;
        e_s = 0; e_v = 0; e_t = 0;
    endtask

    task automatic strobe_rd(input int r, input bit rd);
        sense_rd = 8'(r); src_rd = 8'(r); temp_rd = 8'(r);
        smp_stb = 1'b1; rd_stb = rd;
        e_s = model(e_s, r, sense_lim, sense_hys);
        e_v = model(e_v, r, src_lim, src_hys);
        e_t = model(e_t, r, temp_lim, temp_hys);
        @(negedge clk);
        smp_stb = 1'b0; rd_stb = 1'b0;
        chk("R2/R3 status", crit_stat, {e_s, e_v, 5'b0, e_t});
        chk("R6 summary", crit_sum, e_s | e_v | e_t);
        chk("R7 therm", therm_n, !(e_s | e_v | e_t));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int lims [5] = '{0, 1, 100, 200, 255};
        int hyss [4] = '{0, 5, 120, 255};

        // R1: reset state
        @(negedge clk);
        chk("R1 stat", crit_stat, 0);
        chk("R1 sum", crit_sum, 0);
        chk("R1 therm", therm_n, 1);
        chk("R1 alert", alert_spike, 0);
        rst_n = 1'b1;

        // R2/R3/R5/R6/R7 sweep with reads mixed in
        for (int li = 0; li < 5; li++) begin
            for (int hi = 0; hi < 4; hi++) begin
                sense_lim = 8'(lims[li]);      sense_hys = 8'(hyss[hi]);
                src_lim   = 8'(lims[li] / 2);  src_hys   = 8'(hyss[hi]);
                temp_lim  = 8'(lims[li] + 37); temp_hys  = 8'(hyss[hi] / 3);
                do_reset();
                for (int r = 0; r < 256; r++) strobe_rd(r, (r % 3) == 0);
                for (int r = 255; r >= 0; r--) strobe_rd(r, (r % 4) == 1);
            end
        end

        // R4: readings cross the limit without a strobe
        sense_lim = 8'd50; src_lim = 8'd50; temp_lim = 8'd50;
        sense_hys = 8'd10; src_hys = 8'd10; temp_hys = 8'd10;
        do_reset();
        sense_rd = 8'd200; src_rd = 8'd200; temp_rd = 8'd200;
        repeat (4) @(negedge clk);
        chk("R4 no strobe", crit_stat, 8'h00);
        strobe_rd(200, 1'b0);
        chk("R2 all set", crit_stat, 8'hC1);
        sense_rd = 0; src_rd = 0; temp_rd = 0; sense_lim = 8'd255;
        repeat (3) @(negedge clk);
        chk("R4 hold set", crit_stat, 8'hC1);

        // R5: read strobe alone with bits set
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        chk("R5 read no clear", crit_stat, 8'hC1);

        // R8: spike to therm, masked input has no effect
        sense_lim = 8'hFF; src_lim = 8'hFF; temp_lim = 8'hFF;
        sense_hys = 0; src_hys = 0; temp_hys = 0;
        do_reset();
        route_therm = 1'b1; peak_mask = 1'b1;
        spike = 1'b1;
        @(negedge clk);
        spike = 1'b0;
        chk("R8 therm low", therm_n, 0);
        chk("R8 no alert", alert_spike, 0);
        chk("R8 stat clear", crit_stat, 0);
        repeat (3) @(negedge clk);
        chk("R8 held", therm_n, 0);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        chk("R8 dropped", therm_n, 1);

        // R9: spike to alert, unmasked then masked
        route_therm = 1'b0; peak_mask = 1'b0;
        spike = 1'b1;
        @(negedge clk);
        spike = 1'b0;
        chk("R9 alert high", alert_spike, 1);
        chk("R9 therm idle", therm_n, 1);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        chk("R9 alert dropped", alert_spike, 0);
        peak_mask = 1'b1;
        spike = 1'b1;
        @(negedge clk);
        spike = 1'b0;
        chk("R9 masked", alert_spike, 0);
        chk("R9 masked therm", therm_n, 1);

        // R10: spike coinciding with strobe
        peak_mask = 1'b0;
        spike = 1'b1;
        @(negedge clk);
        chk("R10 first hold", alert_spike, 1);
        smp_stb = 1'b1;
        @(negedge clk);
        spike = 1'b0; smp_stb = 1'b0;
        chk("R10 kept on collide", alert_spike, 1);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        chk("R10 later drop", alert_spike, 0);
        route_therm = 1'b1;
        spike = 1'b1; smp_stb = 1'b1;
        @(negedge clk);
        spike = 1'b0; smp_stb = 1'b0;
        chk("R10 therm collide", therm_n, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule